// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block orders the power-up and power-down of a smart card contact interface. A host asks for a session by driving a request line low. The sequencer checks that a card is seated and that the supply is healthy. It then steps through a fixed timeline measured in ticks of a slow timebase. First it turns on the step-up converter. Next it releases the low-impedance clamp and starts the card supply ramp. It then connects the I/O line and runs the card clock, and finally it enables the card reset driver. In the window between connecting I/O and enabling reset, the host reset line gates the card clock directly, so the host can count clock pulses exactly. Once reset is enabled the clock runs freely and the card reset pin follows the inverse of the host line.

Power-down uses the reverse order: reset low, I/O isolated, clock stopped, supply ramped down, then converter off and all contacts clamped low. It starts when the host raises the request line. It also starts on its own when overcurrent, a contact short, a supply drop or card removal is detected during a session. In the automatic case an active-low alert output warns the host. The alert clears when power-down completes, except after a card removal, where it stays low until a card is inserted again.

The tick is a single-cycle pulse from an external divider, nominally one every 25 µs. All asynchronous inputs pass through a synchronizer of `SYNC_STAGES` flops, so the block reacts `SYNC_STAGES`+1 clock edges after an input changes.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, clamp_en is 1, stepup_en, vcc_en, io_en, clk_en, rst_en and card_rst are 0, and alert_n is 1.
- R2: A session starts only on a falling edge of sess_req_n while card_present is 1 and supply_low, fault_ovc and fault_short are 0. A falling edge with any of these conditions unmet leaves all outputs in the idle state.
- R3: On acceptance, stepup_en rises at once, with clamp_en still 1 and vcc_en 0. One tick later clamp_en falls and vcc_en rises. Four ticks after acceptance io_en rises. Seven ticks after acceptance rst_en rises. No output rises out of this order.
- R4: From io_en rising until rst_en rises, clk_en equals host_rst and card_rst is 0.
- R5: Once rst_en is 1 in a running session, clk_en is 1 whatever host_rst does, and card_rst equals the inverse of host_rst.
- R6: On a power-down trigger, card_rst drops at once. Counting ticks from the trigger, io_en falls after 1, clk_en after 2, vcc_en after 3, and after 5 stepup_en and rst_en fall and clamp_en rises (idle).
- R7: During power-up or a running session, each of these starts power-down: sess_req_n high, fault_ovc, fault_short, supply_low, or card_present low. A trigger that arrives in the same clock cycle as a tick wins over that tick.
- R8: A fault, supply drop or removal during a session drives alert_n low from the trigger. A power-down requested through sess_req_n leaves alert_n high. For causes other than removal, alert_n returns to 1 one cycle after the idle state is reached.
- R9: After a power-down caused by card removal, alert_n stays 0 in the idle state until card_present is 1 again.
- R10: A falling edge of sess_req_n during power-down is ignored. The block stays idle after power-down until a new falling edge arrives.
- R11: While idle, io_en, clk_en, card_rst and vcc_en are 0, so the I/O line stays isolated and the contacts stay low.
- R12: If power-down interrupts power-up, an enable that had not yet risen stays 0 for the whole power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that advances the sequencer |
| sess_req_n | input | 1 | Session request, active low |
| card_present | input | 1 | Card seated in the connector |
| supply_low | input | 1 | Supply supervisor reports low voltage |
| fault_ovc | input | 1 | Overcurrent on the card supply |
| fault_short | input | 1 | Short between card supply and another contact |
| host_rst | input | 1 | Host card reset control; gates clock in the counting window |
| stepup_en | output | 1 | Step-up converter enable |
| vcc_en | output | 1 | Card supply ramp enable |
| clamp_en | output | 1 | Low-impedance clamp of all contacts to ground |
| io_en | output | 1 | Connects card I/O to the character UART |
| clk_en | output | 1 | Card clock enable |
| rst_en | output | 1 | Card reset driver enable |
| card_rst | output | 1 | Level driven on the card reset contact |
| alert_n | output | 1 | Active-low warning of automatic power-down |

## Verification
A power-down trigger and the tick that would otherwise move power-up on to its next step can reach the phase logic in the same clock edge. The bench creates this collision by raising an overcurrent input and timing the tick so that it lands on exactly the edge where the synchronized fault first appears. This is done with power-up one tick short of enabling reset. The design passes if power-down starts from that point: reset never enables, I/O is still connected on the first power-down sample, and the remaining drain timeline follows the tick counts of R6.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAMP  = 2'd1,
    PH_LIVE  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cps_guard.sv
module cps_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_req_n,
  input  logic card_present,
  input  logic supply_low,
  input  logic fault_ovc,
  input  logic fault_short,
  output logic req_fall,
  output logic req_stop,
  output logic present_s,
  output logic fault_any
);

  localparam int NIN = 5;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] syn;
  logic           req_prev_q;
  logic           req_prev_d;

  assign raw = {sess_req_n, card_present, supply_low, fault_ovc, fault_short};

  cps_sync #(
    .W       (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (5'b10000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn)
  );

  assign req_stop  = syn[4];
  assign present_s = syn[3];
  assign fault_any = syn[2] | syn[1] | syn[0] | ~syn[3];

  assign req_prev_d = syn[4];
  assign req_fall   = req_prev_q & ~syn[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev_q <= 1'b1;
    else        req_prev_q <= req_prev_d;
  end

  AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fall |=> !req_fall); // R2

endmodule

// File: rtl/cps_timeline.sv
module cps_timeline
  import cps_pkg::*;
#(
  parameter int UP_VCC = 1,
  parameter int UP_IO  = 4,
  parameter int UP_RST = 7,
  parameter int DN_END = 5,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_fall,
  input  logic             req_stop,
  input  logic             fault_any,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             had_vcc,
  output logic             had_io,
  output logic             had_live
);

  localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(UP_RST - 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DN_END - 1);
  localparam logic [CNT_W-1:0] VCC_AT     = CNT_W'(UP_VCC);
  localparam logic [CNT_W-1:0] IO_AT      = CNT_W'(UP_IO);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             hv_d, hi_d, hl_d;
  logic             trip;

  assign trip = req_stop | fault_any;

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    hv_d    = had_vcc;
    hi_d    = had_io;
    hl_d    = had_live;
    unique case (phase)
      PH_IDLE: begin
        if (req_fall && !fault_any) begin
          phase_d = PH_RAMP;
          cnt_d   = '0;
        end
      end
      PH_RAMP: begin
        if (trip) begin
          phase_d = PH_DRAIN;
          cnt_d   = '0;
          hv_d    = (cnt >= VCC_AT);
          hi_d    = (cnt >= IO_AT);
          hl_d    = 1'b0;
        end else if (tick) begin
          if (cnt == RAMP_LAST) begin
            phase_d = PH_LIVE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
      end
      PH_LIVE: begin
        if (trip) begin
          phase_d = PH_DRAIN;
          cnt_d   = '0;
          hv_d    = 1'b1;
          hi_d    = 1'b1;
          hl_d    = 1'b1;
        end
      end
      PH_DRAIN: begin
        if (tick) begin
          if (cnt == DRAIN_LAST) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
            hv_d    = 1'b0;
            hi_d    = 1'b0;
            hl_d    = 1'b0;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      had_vcc  <= 1'b0;
      had_io   <= 1'b0;
      had_live <= 1'b0;
    end else begin
      phase    <= phase_d;
      cnt      <= cnt_d;
      had_vcc  <= hv_d;
      had_io   <= hi_d;
      had_live <= hl_d;
    end
  end

  AST_DRAIN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN) |=> (phase != PH_RAMP)); // R10
  AST_TRIP_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RAMP || phase == PH_LIVE) && trip) |=> (phase == PH_DRAIN)); // R7
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RAMP) |-> (cnt <= RAMP_LAST)); // R3
  AST_DRAIN_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN) |-> (cnt <= DRAIN_LAST)); // R6

endmodule

// File: rtl/cps_drive.sv
module cps_drive
  import cps_pkg::*;
#(
  parameter int UP_VCC = 1,
  parameter int UP_IO  = 4,
  parameter int DN_IO  = 1,
  parameter int DN_CLK = 2,
  parameter int DN_VCC = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             had_vcc,
  input  logic             had_io,
  input  logic             had_live,
  input  logic             host_rst,
  input  logic             fault_any,
  input  logic             present_s,
  output logic             stepup_en,
  output logic             vcc_en,
  output logic             clamp_en,
  output logic             io_en,
  output logic             clk_en,
  output logic             rst_en,
  output logic             card_rst,
  output logic             alert_n
);

  localparam logic [CNT_W-1:0] VCC_AT  = CNT_W'(UP_VCC);
  localparam logic [CNT_W-1:0] IO_AT   = CNT_W'(UP_IO);
  localparam logic [CNT_W-1:0] IO_OFF  = CNT_W'(DN_IO);
  localparam logic [CNT_W-1:0] CLK_OFF = CNT_W'(DN_CLK);
  localparam logic [CNT_W-1:0] VCC_OFF = CNT_W'(DN_VCC);

  logic alert_q, alert_d;
  logic gone_q, gone_d;

  // contact decode from phase and step count
  always_comb begin
    stepup_en = 1'b0;
    vcc_en    = 1'b0;
    clamp_en  = 1'b1;
    io_en     = 1'b0;
    clk_en    = 1'b0;
    rst_en    = 1'b0;
    card_rst  = 1'b0;
    unique case (phase)
      PH_IDLE: ;
      PH_RAMP: begin
        stepup_en = 1'b1;
        clamp_en  = (cnt < VCC_AT);
        vcc_en    = (cnt >= VCC_AT);
        io_en     = (cnt >= IO_AT);
        clk_en    = (cnt >= IO_AT) & host_rst;
      end
      PH_LIVE: begin
        stepup_en = 1'b1;
        clamp_en  = 1'b0;
        vcc_en    = 1'b1;
        io_en     = 1'b1;
        clk_en    = 1'b1;
        rst_en    = 1'b1;
        card_rst  = ~host_rst;
      end
      PH_DRAIN: begin
        stepup_en = 1'b1;
        clamp_en  = 1'b0;
        io_en     = had_io   & (cnt < IO_OFF);
        clk_en    = had_live & (cnt < CLK_OFF);
        vcc_en    = had_vcc  & (cnt < VCC_OFF);
        rst_en    = had_live;
      end
      default: ;
    endcase
  end

  // warning latch: set by a trip in a session, cleared once idle
  always_comb begin
    alert_d = alert_q;
    gone_d  = gone_q;
    if (phase != PH_IDLE) begin
      if (fault_any) begin
        alert_d = 1'b1;
        gone_d  = gone_q | ~present_s;
      end
    end else if (alert_q) begin
      if (!gone_q) begin
        alert_d = 1'b0;
      end else if (present_s) begin
        alert_d = 1'b0;
        gone_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      gone_q  <= 1'b0;
    end else begin
      alert_q <= alert_d;
      gone_q  <= gone_d;
    end
  end

  assign alert_n = ~alert_q;

  AST_CLAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> !(vcc_en || io_en || clk_en || rst_en || card_rst)); // R11
  AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> (vcc_en && stepup_en)); // R3
  AST_VCC_NEEDS_STEPUP: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> (stepup_en && !clamp_en)); // R6
  AST_RST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (clk_en && io_en && rst_en)); // R5
  AST_FAULT_ALERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && fault_any) |=> !alert_n); // R8
  AST_REMOVAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && gone_q && !present_s) |=> !alert_n); // R9

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import cps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UP_VCC      = 1,
  parameter int UP_IO       = 4,
  parameter int UP_RST      = 7,
  parameter int DN_IO       = 1,
  parameter int DN_CLK      = 2,
  parameter int DN_VCC      = 3,
  parameter int DN_END      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sess_req_n,
  input  logic card_present,
  input  logic supply_low,
  input  logic fault_ovc,
  input  logic fault_short,
  input  logic host_rst,
  output logic stepup_en,
  output logic vcc_en,
  output logic clamp_en,
  output logic io_en,
  output logic clk_en,
  output logic rst_en,
  output logic card_rst,
  output logic alert_n
);

  localparam int CNT_MAX = (UP_RST > DN_END) ? UP_RST : DN_END;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             req_fall, req_stop, present_s, fault_any;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             had_vcc, had_io, had_live;

  cps_guard #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .sess_req_n   (sess_req_n),
    .card_present (card_present),
    .supply_low   (supply_low),
    .fault_ovc    (fault_ovc),
    .fault_short  (fault_short),
    .req_fall     (req_fall),
    .req_stop     (req_stop),
    .present_s    (present_s),
    .fault_any    (fault_any)
  );

  cps_timeline #(
    .UP_VCC (UP_VCC),
    .UP_IO  (UP_IO),
    .UP_RST (UP_RST),
    .DN_END (DN_END),
    .CNT_W  (CNT_W)
  ) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .req_fall  (req_fall),
    .req_stop  (req_stop),
    .fault_any (fault_any),
    .phase     (phase),
    .cnt       (cnt),
    .had_vcc   (had_vcc),
    .had_io    (had_io),
    .had_live  (had_live)
  );

  cps_drive #(
    .UP_VCC (UP_VCC),
    .UP_IO  (UP_IO),
    .DN_IO  (DN_IO),
    .DN_CLK (DN_CLK),
    .DN_VCC (DN_VCC),
    .CNT_W  (CNT_W)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cnt       (cnt),
    .had_vcc   (had_vcc),
    .had_io    (had_io),
    .had_live  (had_live),
    .host_rst  (host_rst),
    .fault_any (fault_any),
    .present_s (present_s),
    .stepup_en (stepup_en),
    .vcc_en    (vcc_en),
    .clamp_en  (clamp_en),
    .io_en     (io_en),
    .clk_en    (clk_en),
    .rst_en    (rst_en),
    .card_rst  (card_rst),
    .alert_n   (alert_n)
  );

  AST_STEPUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stepup_en) |-> (clamp_en && !vcc_en && !io_en)); // R3
  AST_RST_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_en) && (req_stop || fault_any)) |=> !card_rst); // R6

endmodule

// File: tb/sim_card_pwr_seq.sv
module sim_card_pwr_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sess_req_n = 1'b1;
  logic card_present = 1'b1;
  logic supply_low = 1'b0;
  logic fault_ovc = 1'b0;
  logic fault_short = 1'b0;
  logic host_rst = 1'b0;
  logic stepup_en, vcc_en, clamp_en, io_en, clk_en, rst_en, card_rst, alert_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  card_pwr_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .sess_req_n   (sess_req_n),
    .card_present (card_present),
    .supply_low   (supply_low),
    .fault_ovc    (fault_ovc),
    .fault_short  (fault_short),
    .host_rst     (host_rst),
    .stepup_en    (stepup_en),
    .vcc_en       (vcc_en),
    .clamp_en     (clamp_en),
    .io_en        (io_en),
    .clk_en       (clk_en),
    .rst_en       (rst_en),
    .card_rst     (card_rst),
    .alert_n      (alert_n)
  );

  // observed vector: {stepup, clamp, vcc, io, clk, rst_en, card_rst, alert_n}
  function automatic logic [7:0] obs();
    return {stepup_en, clamp_en, vcc_en, io_en, clk_en, rst_en, card_rst, alert_n};
  endfunction

  function automatic logic [7:0] exp_idle(logic al);
    return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, al};
  endfunction

  function automatic logic [7:0] exp_ramp(int k, logic ri);
    if (k >= 7) return {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, ~ri, 1'b1};
    return {1'b1, (k < 1), (k >= 1), (k >= 4), ((k >= 4) && ri), 1'b0, 1'b0, 1'b1};
  endfunction

  function automatic logic [7:0] exp_drain(int j, logic hv, logic hi, logic hl, logic al);
    if (j >= 5) return exp_idle(al);
    return {1'b1, 1'b0, (hv && j < 3), (hi && j < 1), (hl && j < 2), hl, 1'b0, al};
  endfunction

  task automatic chk(input string tag, input logic [7:0] expv);
    checks++;
    if (obs() !== expv) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", tag, obs(), expv);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic rejected(input string tag);
    waitn(4);
    sess_req_n = 1'b0;
    waitn(5);
    chk(tag, exp_idle(1'b1));
    do_tick();
    waitn(1);
    chk(tag, exp_idle(1'b1));
    sess_req_n = 1'b1;
    card_present = 1'b1;
    supply_low = 1'b0;
    fault_ovc = 1'b0;
    waitn(4);
  endtask

  // trig: 0 request high, 1 overcurrent, 2 short, 3 removal, 4 supply drop
  task automatic session(input int trig, input int kk);
    logic hv, hi, hl, al;
    waitn(4);
    sess_req_n = 1'b0;
    host_rst = 1'b0;
    waitn(4);
    chk("R3 stepup first", exp_ramp(0, 1'b0));
    for (int k = 1; k <= kk; k++) begin
      host_rst = k[0];
      do_tick();
      waitn(1);
      if (k >= 4 && k < 7) chk("R4 counting window", exp_ramp(k, host_rst));
      else                 chk("R3 power-up order", exp_ramp(k, host_rst));
    end
    if (kk == 7) begin
      host_rst = ~host_rst;
      waitn(2);
      chk("R5 free clock", exp_ramp(7, host_rst));
    end
    hv = (kk >= 1);
    hi = (kk >= 4);
    hl = (kk >= 7);
    al = (trig == 0);
    case (trig)
      0: sess_req_n = 1'b1;
      1: fault_ovc = 1'b1;
      2: fault_short = 1'b1;
      3: card_present = 1'b0;
      default: supply_low = 1'b1;
    endcase
    waitn(4);
    fault_ovc = 1'b0;
    fault_short = 1'b0;
    supply_low = 1'b0;
    chk((kk < 7) ? "R12 drain from ramp" : "R7 trigger", exp_drain(0, hv, hi, hl, al));
    for (int j = 1; j <= 5; j++) begin
      if (trig == 0 && j == 2) sess_req_n = 1'b0;
      do_tick();
      waitn(2);
      if (j == 5) chk("R8 end of drain", exp_drain(5, hv, hi, hl, (trig != 3)));
      else if (kk < 7) chk("R12 drain order", exp_drain(j, hv, hi, hl, al));
      else chk("R6 drain order", exp_drain(j, hv, hi, hl, al));
    end
    if (trig == 0) begin
      waitn(6);
      chk("R10 request in drain ignored", exp_idle(1'b1));
      sess_req_n = 1'b1;
    end else begin
      sess_req_n = 1'b1;
    end
    if (trig == 3) begin
      do_tick();
      waitn(3);
      chk("R9 alert held after removal", exp_idle(1'b0));
      card_present = 1'b1;
      waitn(5);
      chk("R9 alert clears on insert", exp_idle(1'b1));
    end
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(3);
    chk("R1 reset state", exp_idle(1'b1));
    chk("R11 idle contacts", exp_idle(1'b1));

    card_present = 1'b0;
    rejected("R2 no card");
    supply_low = 1'b1;
    rejected("R2 supply low");
    fault_ovc = 1'b1;
    rejected("R2 overcurrent");

    for (int t = 0; t < 5; t++)
      for (int k = 0; k <= 7; k++)
        session(t, k);

    // collision: overcurrent meets the tick that would enable reset
    waitn(4);
    sess_req_n = 1'b0;
    waitn(4);
    for (int k = 1; k <= 6; k++) do_tick();
    @(negedge clk) fault_ovc = 1'b1;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    fault_ovc = 1'b0;
    sess_req_n = 1'b1;
    waitn(1);
    chk("R7 trip beats tick", exp_drain(0, 1'b1, 1'b1, 1'b0, 1'b0));
    for (int j = 1; j <= 5; j++) begin
      do_tick();
      waitn(2);
      chk((j == 5) ? "R8 collision end" : "R7 collision drain",
          exp_drain(j, 1'b1, 1'b1, 1'b0, (j == 5)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule